// File: doc/BRIEF.md
# Lock-Aware Instruction Cache Invalidation Controller

This block manages invalidation of a small direct-mapped instruction cache tag array in which every line carries a valid bit, a tag and a lock bit. It takes two commands. Flush-all clears the array and pulses a branch predictor flush. Flush-by-address clears the one line that the address selects, and only when that line holds a valid matching tag. The data path, refill and lock management lie outside this block. Lines are loaded directly through a simple fill port, and a read port exposes any line for inspection.

Three context inputs (debug state, secure user mode, and permission for invasive debug at secure privileged levels) choose between normal and protected operation. In protected operation locked lines survive both commands. Flush-all may then report an abort, but only together with completion, after every unlocked line has been cleared. Flush-by-address on a locked line either does nothing or aborts. Parameters choose the abort policy for each command and can remove line locking altogether.

The controller is a four-state machine. `ST_IDLE` waits for a command. Accepting flush-all moves it to `ST_WALK`, and accepting flush-by-address moves it to `ST_ADDR`. `ST_WALK` visits one line per cycle from index 0 upward and moves to `ST_FIN` after the last index. `ST_ADDR` compares the tag for one cycle and then moves to `ST_FIN`. `ST_FIN` presents done and any abort for one cycle and always returns to `ST_IDLE`.

Top module: `icache_inval_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every valid bit and every lock bit and returns the block to idle, with busy, done, abort and bp_flush all low.
- R2: bp_flush is high for exactly one cycle, the cycle after a flush-all command (cmd_op=0) is accepted, whatever the mode or the lock bits. It never rises for a flush-by-address command (cmd_op=1).
- R3: In normal mode, flush-all clears every line, locked ones included. Done is high in cycle LINES+1 after the accepting edge, low in cycle LINES, and abort is low.
- R4: Protected mode applies only when dbg_halted=1, sec_user=1 and sec_priv_dbg_ok=0 at the accepting edge. Any other combination gives normal behaviour.
- R5: In protected mode, flush-all clears every unlocked line and leaves each locked line with its valid bit and tag unchanged.
- R6: In protected mode with ABORT_ON_ALL=1, flush-all raises abort together with done if any lock bit was set. With no lock bit set, or with ABORT_ON_ALL=0, abort stays low.
- R7: cmd_addr is {tag, index}, with the index in the low log2(LINES) bits. A flush-by-address whose index holds a valid line with an equal tag clears that line. A miss changes nothing. In both cases done is high in cycle 2 after the accepting edge and abort is low.
- R8: In protected mode, a flush-by-address that hits a locked line leaves the line valid. Abort is raised with done when ABORT_ON_ADDR=1 and stays low when it is 0.
- R9: A command is accepted only in idle. busy is high from the cycle after acceptance through the done cycle and low in the cycle after that. cmd_valid held while busy starts no new command.
- R10: A fill sets the selected line valid with the given tag and lock bit, visible on the read port in the next cycle. With LOCK_ENABLE=0 every lock bit reads 0, and protected mode behaves exactly like normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken only when idle |
| cmd_op | input | 1 | 0 = flush-all, 1 = flush-by-address |
| cmd_addr | input | TAG_W+log2(LINES) | {tag, index} for flush-by-address |
| dbg_halted | input | 1 | Core is in debug state |
| sec_user | input | 1 | Core is in secure user mode |
| sec_priv_dbg_ok | input | 1 | Invasive debug permitted at secure privileged levels |
| fill_en | input | 1 | Load one line; ignored while busy |
| fill_idx | input | log2(LINES) | Line to load |
| fill_tag | input | TAG_W | Tag to store |
| fill_lock | input | 1 | Lock bit to store |
| rd_idx | input | log2(LINES) | Line to inspect |
| rd_valid | output | 1 | Valid bit of the inspected line |
| rd_lock | output | 1 | Lock bit of the inspected line |
| rd_tag | output | TAG_W | Tag of the inspected line |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| abort | output | 1 | Abort status, valid only with done |
| bp_flush | output | 1 | One-cycle branch predictor flush strobe |

## Verification
Each result is due on a fixed cycle after the accepting edge. bp_flush appears in cycle 1. Flush-by-address gives done in cycle 2, and flush-all gives done in cycle LINES+1, with busy dropping one cycle later. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the accepting one, so each output is read in its due cycle, and it also confirms done is still low in the cycle before. Line contents are read through the read port only after busy has dropped. Three instances with different abort and locking parameters run on the same stimulus, so each policy is checked against the same cycle schedule.

// File: rtl/icinv_pkg.sv
package icinv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_ADDR = 2'd2,
        ST_FIN  = 2'd3
    } icinv_state_e;

    typedef enum logic {
        OP_ALL  = 1'b0,
        OP_ADDR = 1'b1
    } icinv_op_e;
endpackage

// File: rtl/icinv_mode.sv
module icinv_mode (
    input  logic dbg_halted,
    input  logic sec_user,
    input  logic sec_priv_dbg_ok,
    output logic restricted
);
    // Protected behaviour needs all three context conditions at once.
    always_comb begin
        restricted = dbg_halted && sec_user && !sec_priv_dbg_ok;
    end
endmodule

// File: rtl/icinv_tag_store.sv
module icinv_tag_store #(
    parameter int LINES       = 16,
    parameter int TAG_W       = 8,
    parameter bit LOCK_ENABLE = 1'b1,
    localparam int IDX_W      = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_lock,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             clr_protect,
    input  logic [IDX_W-1:0] probe_idx,
    output logic             probe_valid,
    output logic             probe_lock,
    output logic [TAG_W-1:0] probe_tag,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_lock,
    output logic [TAG_W-1:0] rd_tag
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] lock_eff;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (clr_en && !(clr_protect && lock_eff[clr_idx])) begin
                valid_q[clr_idx] <= 1'b0;
            end
            if (fill_en) begin
                valid_q[fill_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx] <= fill_tag;
        end
    end

    generate
        if (LOCK_ENABLE) begin : g_lock
            logic [LINES-1:0] lock_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    lock_q <= '0;
                end else if (fill_en) begin
                    lock_q[fill_idx] <= fill_lock;
                end
            end
            assign lock_eff = lock_q;
        end else begin : g_nolock
            assign lock_eff = '0;
        end
    endgenerate

    always_comb begin
        probe_valid = valid_q[probe_idx];
        probe_lock  = lock_eff[probe_idx];
        probe_tag   = tag_q[probe_idx];
        rd_valid    = valid_q[rd_idx];
        rd_lock     = lock_eff[rd_idx];
        rd_tag      = tag_q[rd_idx];
    end

    // R5
    locked_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && clr_protect && lock_eff[clr_idx] && !fill_en)
        |=> valid_q[$past(clr_idx)] == $past(valid_q[clr_idx]));

    // R10
    fill_sets_chk: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> valid_q[$past(fill_idx)]);
endmodule

// File: rtl/icinv_fsm.sv
module icinv_fsm
    import icinv_pkg::*;
#(
    parameter int LINES         = 16,
    parameter int TAG_W         = 8,
    parameter bit ABORT_ON_ALL  = 1'b1,
    parameter bit ABORT_ON_ADDR = 1'b1,
    localparam int IDX_W        = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_op,
    input  logic [TAG_W-1:0] cmd_tag,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic             restricted,
    input  logic             probe_valid,
    input  logic             probe_lock,
    input  logic [TAG_W-1:0] probe_tag,
    output logic [IDX_W-1:0] probe_idx,
    output logic             clr_en,
    output logic             clr_protect,
    output logic             busy,
    output logic             done,
    output logic             abort,
    output logic             bp_flush
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    icinv_state_e     state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [TAG_W-1:0] tag_q, tag_d;
    logic             restr_q, restr_d;
    logic             abort_q, abort_d;
    logic             bp_q, bp_d;
    logic             hit;

    assign hit = probe_valid && (probe_tag == tag_q);

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        tag_d   = tag_q;
        restr_d = restr_q;
        abort_d = abort_q;
        bp_d    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    restr_d = restricted;
                    abort_d = 1'b0;
                    tag_d   = cmd_tag;
                    if (icinv_op_e'(cmd_op) == OP_ALL) begin
                        state_d = ST_WALK;
                        idx_d   = '0;
                        bp_d    = 1'b1;
                    end else begin
                        state_d = ST_ADDR;
                        idx_d   = cmd_idx;
                    end
                end
            end
            ST_WALK: begin
                if (ABORT_ON_ALL && restr_q && probe_lock) begin
                    abort_d = 1'b1;
                end
                if (idx_q == LAST_IDX) begin
                    state_d = ST_FIN;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_ADDR: begin
                if (ABORT_ON_ADDR && restr_q && probe_lock && hit) begin
                    abort_d = 1'b1;
                end
                state_d = ST_FIN;
            end
            ST_FIN: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            tag_q   <= '0;
            restr_q <= 1'b0;
            abort_q <= 1'b0;
            bp_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            tag_q   <= tag_d;
            restr_q <= restr_d;
            abort_q <= abort_d;
            bp_q    <= bp_d;
        end
    end

    always_comb begin
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_FIN);
        abort       = (state_q == ST_FIN) && abort_q;
        bp_flush    = bp_q;
        probe_idx   = idx_q;
        clr_protect = restr_q;
        clr_en      = (state_q == ST_WALK) || ((state_q == ST_ADDR) && hit);
    end

    // R2
    bp_single_chk: assert property (@(posedge clk) disable iff (rst)
        bp_flush |=> !bp_flush);

    // R9
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R9
    fin_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R6
    abort_done_chk: assert property (@(posedge clk) disable iff (rst)
        abort |-> done);
endmodule

// File: rtl/icache_inval_ctrl.sv
module icache_inval_ctrl #(
    parameter int LINES         = 16,
    parameter int TAG_W         = 8,
    parameter bit LOCK_ENABLE   = 1'b1,
    parameter bit ABORT_ON_ALL  = 1'b1,
    parameter bit ABORT_ON_ADDR = 1'b1,
    localparam int IDX_W        = $clog2(LINES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    input  logic                   cmd_op,
    input  logic [TAG_W+IDX_W-1:0] cmd_addr,
    input  logic                   dbg_halted,
    input  logic                   sec_user,
    input  logic                   sec_priv_dbg_ok,
    input  logic                   fill_en,
    input  logic [IDX_W-1:0]       fill_idx,
    input  logic [TAG_W-1:0]       fill_tag,
    input  logic                   fill_lock,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic                   rd_valid,
    output logic                   rd_lock,
    output logic [TAG_W-1:0]       rd_tag,
    output logic                   busy,
    output logic                   done,
    output logic                   abort,
    output logic                   bp_flush
);
    logic             restricted;
    logic [IDX_W-1:0] probe_idx;
    logic             probe_valid, probe_lock;
    logic [TAG_W-1:0] probe_tag;
    logic             clr_en, clr_protect;
    logic             fill_gated;

    assign fill_gated = fill_en && !busy;

    icinv_mode u_mode (
        .dbg_halted      (dbg_halted),
        .sec_user        (sec_user),
        .sec_priv_dbg_ok (sec_priv_dbg_ok),
        .restricted      (restricted)
    );

    icinv_tag_store #(
        .LINES       (LINES),
        .TAG_W       (TAG_W),
        .LOCK_ENABLE (LOCK_ENABLE)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .fill_en     (fill_gated),
        .fill_idx    (fill_idx),
        .fill_tag    (fill_tag),
        .fill_lock   (fill_lock),
        .clr_en      (clr_en),
        .clr_idx     (probe_idx),
        .clr_protect (clr_protect),
        .probe_idx   (probe_idx),
        .probe_valid (probe_valid),
        .probe_lock  (probe_lock),
        .probe_tag   (probe_tag),
        .rd_idx      (rd_idx),
        .rd_valid    (rd_valid),
        .rd_lock     (rd_lock),
        .rd_tag      (rd_tag)
    );

    icinv_fsm #(
        .LINES         (LINES),
        .TAG_W         (TAG_W),
        .ABORT_ON_ALL  (ABORT_ON_ALL),
        .ABORT_ON_ADDR (ABORT_ON_ADDR)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_tag     (cmd_addr[TAG_W+IDX_W-1:IDX_W]),
        .cmd_idx     (cmd_addr[IDX_W-1:0]),
        .restricted  (restricted),
        .probe_valid (probe_valid),
        .probe_lock  (probe_lock),
        .probe_tag   (probe_tag),
        .probe_idx   (probe_idx),
        .clr_en      (clr_en),
        .clr_protect (clr_protect),
        .busy        (busy),
        .done        (done),
        .abort       (abort),
        .bp_flush    (bp_flush)
    );
endmodule

// File: tb/icache_inval_ctrl_test.sv
module icache_inval_ctrl_test;
    localparam int LINES = 16;
    localparam int TAG_W = 8;
    localparam int IDX_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0, cmd_op = 1'b0;
    logic [TAG_W+IDX_W-1:0] cmd_addr = '0;
    logic dbg_halted = 1'b0, sec_user = 1'b0, sec_priv_dbg_ok = 1'b0;
    logic fill_en = 1'b0, fill_lock = 1'b0;
    logic [IDX_W-1:0] fill_idx = '0, rd_idx = '0;
    logic [TAG_W-1:0] fill_tag = '0;

    logic rv_m, rl_m, busy_m, done_m, ab_m, bp_m;
    logic rv_q, rl_q, busy_q, done_q, ab_q, bp_q;
    logic rv_n, rl_n, busy_n, done_n, ab_n, bp_n;
    logic [TAG_W-1:0] rt_m, rt_q, rt_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    icache_inval_ctrl uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .dbg_halted(dbg_halted), .sec_user(sec_user), .sec_priv_dbg_ok(sec_priv_dbg_ok),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_lock(fill_lock),
        .rd_idx(rd_idx), .rd_valid(rv_m), .rd_lock(rl_m), .rd_tag(rt_m),
        .busy(busy_m), .done(done_m), .abort(ab_m), .bp_flush(bp_m));

    icache_inval_ctrl #(.ABORT_ON_ALL(1'b0), .ABORT_ON_ADDR(1'b0)) uut_quiet (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .dbg_halted(dbg_halted), .sec_user(sec_user), .sec_priv_dbg_ok(sec_priv_dbg_ok),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_lock(fill_lock),
        .rd_idx(rd_idx), .rd_valid(rv_q), .rd_lock(rl_q), .rd_tag(rt_q),
        .busy(busy_q), .done(done_q), .abort(ab_q), .bp_flush(bp_q));

    icache_inval_ctrl #(.LOCK_ENABLE(1'b0)) uut_nolock (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .dbg_halted(dbg_halted), .sec_user(sec_user), .sec_priv_dbg_ok(sec_priv_dbg_ok),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_lock(fill_lock),
        .rd_idx(rd_idx), .rd_valid(rv_n), .rd_lock(rl_n), .rd_tag(rt_n),
        .busy(busy_n), .done(done_n), .abort(ab_n), .bp_flush(bp_n));

    typedef struct packed {
        logic [3:0] idx;
        logic [7:0] ftag;
        logic       lk;
        logic [7:0] qtag;
        logic       dbg;
        logic       su;
        logic       pok;
        logic       exp_valid;
        logic       exp_abort;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{4'd1, 8'h11, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'd2, 8'h22, 1'b1, 8'h22, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'd3, 8'h33, 1'b1, 8'h33, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{4'd4, 8'h44, 1'b0, 8'h44, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd5, 8'h55, 1'b1, 8'h56, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{4'd6, 8'h66, 1'b1, 8'h66, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd7, 8'h77, 1'b1, 8'h77, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'd8, 8'h88, 1'b0, 8'h89, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        cmd_valid = 1'b0;
        fill_en = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic fill(input logic [3:0] i, input logic [7:0] t, input logic l);
        fill_en = 1'b1; fill_idx = i; fill_tag = t; fill_lock = l;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic look(input logic [3:0] i);
        rd_idx = i;
        #1;
    endtask

    task automatic set_mode(input logic d, input logic s, input logic p);
        dbg_halted = d; sec_user = s; sec_priv_dbg_ok = p;
    endtask

    // Ends at the falling edge of cycle 1 after the accepting edge.
    task automatic issue(input logic op, input logic [11:0] addr);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic flush_all_run(input logic exp_m, input string tag, input logic hold_busy);
        issue(1'b0, 12'h000);
        chk({"R2 bp_flush cycle1 ", tag}, {bp_m, bp_q, bp_n}, 3'b111);
        chk({"R9 busy cycle1 ", tag}, busy_m, 1'b1);
        if (hold_busy) cmd_valid = 1'b1;
        @(negedge clk);
        chk({"R2 bp_flush single ", tag}, {bp_m, bp_q, bp_n}, 3'b000);
        repeat (LINES - 2) @(negedge clk);
        chk({"R3 done low cycle N ", tag}, {done_m, done_q, done_n}, 3'b000);
        @(negedge clk);
        chk({"R3 done cycle N+1 ", tag}, {done_m, done_q, done_n}, 3'b111);
        chk({"R6 abort ", tag}, {ab_m, ab_q, ab_n}, {exp_m, 2'b00});
        cmd_valid = 1'b0;
        @(negedge clk);
        chk({"R9 idle after done ", tag}, {busy_m, busy_q, busy_n, bp_m}, 4'b0000);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 outputs after reset", {busy_m, done_m, ab_m, bp_m}, 4'b0000);
        for (int i = 0; i < LINES; i++) begin
            look(4'(i));
            chk("R1 line cleared", {rv_m, rl_m}, 2'b00);
        end

        // R10: fill visible on read port
        fill(4'd12, 8'hAB, 1'b1);
        look(4'd12);
        chk("R10 fill main", {rv_m, rl_m, rt_m}, {2'b11, 8'hAB});
        chk("R10 fill nolock lock reads 0", {rv_n, rl_n, rt_n}, {2'b10, 8'hAB});

        // Table of flush-by-address vectors: R4 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            logic hit;
            hit = (VECS[v].qtag == VECS[v].ftag);
            fill(VECS[v].idx, VECS[v].ftag, VECS[v].lk);
            set_mode(VECS[v].dbg, VECS[v].su, VECS[v].pok);
            issue(1'b1, {VECS[v].qtag, VECS[v].idx});
            chk("R2 no flush for addr cmd", {bp_m, bp_q, bp_n}, 3'b000);
            chk("R7 done low in cycle1", done_m, 1'b0);
            @(negedge clk);
            chk("R7 done cycle2", {done_m, done_q, done_n}, 3'b111);
            chk("R8 abort main", ab_m, VECS[v].exp_abort);
            chk("R8 abort quiet/nolock", {ab_q, ab_n}, 2'b00);
            @(negedge clk);
            chk("R9 busy drops", {busy_m, busy_q, busy_n}, 3'b000);
            look(VECS[v].idx);
            chk("R4 R7 R8 valid main", rv_m, VECS[v].exp_valid);
            chk("R8 valid quiet", rv_q, VECS[v].exp_valid);
            chk("R10 valid nolock", rv_n, !hit);
        end

        // R5 R6: protected flush-all with locked lines, busy-time command ignored
        do_reset();
        look(4'd12);
        chk("R1 lock cleared by reset", {rv_m, rl_m}, 2'b00);
        fill(4'd0, 8'hA0, 1'b1);
        fill(4'd3, 8'hA3, 1'b0);
        fill(4'd5, 8'hA5, 1'b0);
        fill(4'd9, 8'hA9, 1'b1);
        fill(4'd15, 8'hAF, 1'b0);
        set_mode(1'b1, 1'b1, 1'b0);
        flush_all_run(1'b1, "protected locked", 1'b1);
        look(4'd0);
        chk("R5 locked line 0 kept", {rv_m, rt_m, rv_q}, {1'b1, 8'hA0, 1'b1});
        look(4'd9);
        chk("R5 locked line 9 kept", {rv_m, rt_m, rv_q}, {1'b1, 8'hA9, 1'b1});
        for (int i = 0; i < LINES; i++) begin
            look(4'(i));
            if (i != 0 && i != 9) chk("R5 unlocked cleared", {rv_m, rv_q}, 2'b00);
            chk("R10 nolock all cleared", rv_n, 1'b0);
        end

        // R6: protected flush-all without locked lines
        do_reset();
        fill(4'd2, 8'hB2, 1'b0);
        fill(4'd10, 8'hBA, 1'b0);
        set_mode(1'b1, 1'b1, 1'b0);
        flush_all_run(1'b0, "protected unlocked", 1'b0);
        look(4'd2);
        chk("R6 line 2 cleared", rv_m, 1'b0);
        look(4'd10);
        chk("R6 line 10 cleared", rv_m, 1'b0);

        // R3: normal flush-all clears locked lines
        do_reset();
        fill(4'd0, 8'hC0, 1'b1);
        fill(4'd15, 8'hCF, 1'b1);
        set_mode(1'b0, 1'b0, 1'b0);
        flush_all_run(1'b0, "normal", 1'b0);
        look(4'd0);
        chk("R3 locked line 0 cleared", {rv_m, rv_q, rv_n}, 3'b000);
        look(4'd15);
        chk("R3 locked line 15 cleared", {rv_m, rv_q, rv_n}, 3'b000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule